// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block measures the marks and spaces of a demodulated infrared receiver signal. It resynchronises the raw input, samples it on a programmable sampling tick, and counts each high or low stretch in ticks. Each finished stretch becomes one 8-bit entry in a bank of 68 entries. The bank is packed four entries per 32-bit word, across 17 words. The first entry is always a mark. After that the entries alternate space, mark, space. A count saturates at 255.

A capture ends in one of three ways: a space saturates, a space reaches the programmed completion count, or the bank fills. When it ends, the block sets a sticky status flag and stops storing. The interrupt output is that flag ANDed with an enable bit. Software reads the capture words through a small word-addressed register port, writes the restart bit, and clears the status.

The controller has four states. `ST_IDLE` waits for the first mark. `ST_MARK` counts a mark. `ST_SPACE` counts a space. `ST_DONE` holds the result.

The transitions are named as follows:
- **start**: IDLE to MARK, on a tick that sees the line active.
- **mark_end**: MARK to SPACE, on a tick that sees the line inactive. It stores the mark.
- **space_end**: SPACE to MARK, on a tick that sees the line active. It stores the space.
- **finish**: SPACE to DONE, when the space count reaches 255 or the completion count. It stores the space.
- **fill**: MARK or SPACE to DONE, when the stored entry was the last one.
- **restart**: any state to IDLE, on a restart write.

Register word addresses are:
- 0x00: control. Bit 0 is the receiver enable, bit 1 is the width-detect enable, and bits [15:8] hold the completion count.
- 0x01: sampling period.
- 0x02: restart.
- 0x03: interrupt enable, in bit 0.
- 0x04: status.
- 0x10 to 0x20: capture words.

Top module: `ir_width_capture`

## Requirements
- R1: After reset, every capture word, the control word, the period word and the status bit read 0, and `irq` is low.
- R2: Entry e is read from word address 0x10 + e/4, in bits [8*(e%4)+7 : 8*(e%4)]. Entry 0 is a mark, and later entries alternate space, mark, space.
- R3: A stored width equals the number of sampling ticks for which the line held that level. A mark longer than 255 ticks is stored as 255.
- R4: A space that reaches 255 ticks is stored as 255. It ends the capture and sets the status bit. Later input changes leave the words unchanged until a restart.
- R5: When control bits [15:8] hold a nonzero value D, a space that reaches D ticks is stored as D and ends the capture. A value of 0 leaves only the 255 limit.
- R6: With value P in the period word (address 0x01), one sampling tick occurs every P+1 clock cycles.
- R7: Capture advances only while control bit 0 and control bit 1 are both 1. Otherwise input activity stores nothing and sets no status.
- R8: Once all 68 entries are stored, the capture ends and the status bit is set. Further input changes leave every word unchanged.
- R9: Writing 1 to bit 0 of address 0x02 clears all capture words and returns the controller to waiting for a mark. It leaves the status bit unchanged.
- R10: The status bit (address 0x04, bit 0) stays set until a write of 1 to that bit, including across restarts and new captures. `irq` equals the status bit ANDed with bit 0 of address 0x03.
- R11: A low input level is a mark. A high level before the first mark is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_rx | input | 1 | Raw demodulated receiver output, low while a burst is present |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Word address for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets these corner cases, and each has a visible failure mode:
- **Mark saturation at 255.** A counter that wraps would store a small value instead of 255.
- **Completion count set to 1 tick more or less.** An off-by-one comparison would store D-1 or D+1.
- **Filling the 68th entry.** An index error would drop the last space, or would keep writing past the bank and alter words afterwards.
- **Period of 0, 1 and 5.** A divider that counts P or P+2 cycles would scale every width.
- **Enables set one at a time.** Capture with only one enable set would show up as nonzero words.
- **Status across restart.** A restart that also cleared status would lose an unserviced interrupt.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MARK,
        ST_SPACE,
        ST_DONE
    } cap_state_e;

    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL     = 6'h00;
    localparam logic [ADDR_W-1:0] A_PERIOD   = 6'h01;
    localparam logic [ADDR_W-1:0] A_RESTART  = 6'h02;
    localparam logic [ADDR_W-1:0] A_IRQEN    = 6'h03;
    localparam logic [ADDR_W-1:0] A_STATUS   = 6'h04;
    localparam logic [ADDR_W-1:0] A_CAP_BASE = 6'h10;

endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rx_raw,
    input  logic                run,
    input  logic [PERIOD_W-1:0] period,
    output logic                rx_act,
    output logic                tick
);

    logic [1:0]          sync_q;
    logic [PERIOD_W-1:0] div_q;
    logic                wrap;

    // two-flop resynchroniser, idle level is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], rx_raw};
        end
    end

    assign rx_act = ~sync_q[1];
    assign wrap   = (div_q >= period);
    assign tick   = run && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || wrap) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/ir_cap_bank.sv
module ir_cap_bank #(
    parameter int unsigned NUM_WORDS = 17,
    parameter int unsigned WIDTH_W   = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                we,
    input  logic [$clog2(NUM_WORDS*4+1)-1:0]    widx,
    input  logic [WIDTH_W-1:0]                  wval,
    output logic [NUM_WORDS*4*WIDTH_W-1:0]      words_flat
);

    localparam int unsigned NUM_ENTRIES = NUM_WORDS * 4;
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES + 1);

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        logic [WIDTH_W-1:0] ent_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (clr) begin
                ent_q <= '0;
            end else if (we && (widx == IDX_W'(e))) begin
                ent_q <= wval;
            end
        end

        assign words_flat[e*WIDTH_W +: WIDTH_W] = ent_q;
    end

endmodule

// File: rtl/ir_cap_regs.sv
module ir_cap_regs
    import ir_cap_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 17,
    parameter int unsigned WIDTH_W   = 8,
    parameter int unsigned PERIOD_W  = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [ADDR_W-1:0]               reg_addr,
    input  logic [4*WIDTH_W-1:0]            reg_wdata,
    input  logic [NUM_WORDS*4*WIDTH_W-1:0]  words_flat,
    input  logic                            done_evt,
    output logic                            cfg_ir_en,
    output logic                            cfg_wid_en,
    output logic [WIDTH_W-1:0]              cfg_done_cnt,
    output logic [PERIOD_W-1:0]             cfg_period,
    output logic                            restart,
    output logic                            status,
    output logic                            irq,
    output logic [4*WIDTH_W-1:0]            reg_rdata
);

    localparam int unsigned WORD_W = 4 * WIDTH_W;

    logic              irq_en_q;
    logic              clr_evt;
    logic [ADDR_W-1:0] cap_off;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata;

    assign restart = reg_wr && (reg_addr == A_RESTART) && reg_wdata[0];
    assign clr_evt = reg_wr && (reg_addr == A_STATUS)  && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ir_en    <= 1'b0;
            cfg_wid_en   <= 1'b0;
            cfg_done_cnt <= '0;
            cfg_period   <= '0;
            irq_en_q     <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL) begin
                cfg_ir_en    <= reg_wdata[0];
                cfg_wid_en   <= reg_wdata[1];
                cfg_done_cnt <= reg_wdata[8 +: WIDTH_W];
            end
            if (reg_addr == A_PERIOD) begin
                cfg_period <= reg_wdata[PERIOD_W-1:0];
            end
            if (reg_addr == A_IRQEN) begin
                irq_en_q <= reg_wdata[0];
            end
        end
    end

    // completion wins over a simultaneous acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= 1'b0;
        end else if (done_evt) begin
            status <= 1'b1;
        end else if (clr_evt) begin
            status <= 1'b0;
        end
    end

    assign irq = status & irq_en_q;

    always_comb begin
        reg_rdata = '0;
        cap_off   = reg_addr - A_CAP_BASE;
        if (reg_addr == A_CTRL) begin
            reg_rdata[0]             = cfg_ir_en;
            reg_rdata[1]             = cfg_wid_en;
            reg_rdata[8 +: WIDTH_W]  = cfg_done_cnt;
        end else if (reg_addr == A_PERIOD) begin
            reg_rdata[PERIOD_W-1:0] = cfg_period;
        end else if (reg_addr == A_IRQEN) begin
            reg_rdata[0] = irq_en_q;
        end else if (reg_addr == A_STATUS) begin
            reg_rdata[0] = status;
        end else if ((reg_addr >= A_CAP_BASE) && (cap_off < ADDR_W'(NUM_WORDS))) begin
            reg_rdata = words_flat[cap_off*WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/ir_width_capture.sv
module ir_width_capture
    import ir_cap_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 17,
    parameter int unsigned WIDTH_W   = 8,
    parameter int unsigned PERIOD_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ir_rx,
    input  logic                 reg_wr,
    input  logic [5:0]           reg_addr,
    input  logic [4*WIDTH_W-1:0] reg_wdata,
    output logic [4*WIDTH_W-1:0] reg_rdata,
    output logic                 irq
);

    localparam int unsigned NUM_ENTRIES = NUM_WORDS * 4;
    localparam int unsigned IDX_W       = $clog2(NUM_ENTRIES + 1);
    localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
    localparam logic [WIDTH_W-1:0] SAT_VAL  = '1;

    cap_state_e state_q, state_d;
    logic [WIDTH_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0]   idx_q, idx_d;

    logic                           cfg_ir_en, cfg_wid_en, run;
    logic [WIDTH_W-1:0]             cfg_done_cnt;
    logic [PERIOD_W-1:0]            cfg_period;
    logic                           restart, status;
    logic                           rx_act, tick;
    logic                           bank_we, done_evt, space_over;
    logic [WIDTH_W-1:0]             cnt_inc;
    logic [NUM_WORDS*4*WIDTH_W-1:0] words_flat;

    assign run = cfg_ir_en & cfg_wid_en;

    ir_cap_sync #(.PERIOD_W(PERIOD_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_raw (ir_rx),
        .run    (run),
        .period (cfg_period),
        .rx_act (rx_act),
        .tick   (tick)
    );

    ir_cap_regs #(
        .NUM_WORDS (NUM_WORDS),
        .WIDTH_W   (WIDTH_W),
        .PERIOD_W  (PERIOD_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .words_flat   (words_flat),
        .done_evt     (done_evt),
        .cfg_ir_en    (cfg_ir_en),
        .cfg_wid_en   (cfg_wid_en),
        .cfg_done_cnt (cfg_done_cnt),
        .cfg_period   (cfg_period),
        .restart      (restart),
        .status       (status),
        .irq          (irq),
        .reg_rdata    (reg_rdata)
    );

    ir_cap_bank #(.NUM_WORDS(NUM_WORDS), .WIDTH_W(WIDTH_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (restart),
        .we         (bank_we),
        .widx       (idx_q),
        .wval       (cnt_q),
        .words_flat (words_flat)
    );

    assign cnt_inc    = (cnt_q == SAT_VAL) ? SAT_VAL : cnt_q + 1'b1;
    assign space_over = run && ((cnt_q == SAT_VAL) ||
                                ((cfg_done_cnt != '0) && (cnt_q >= cfg_done_cnt)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        idx_d    = idx_q;
        bank_we  = 1'b0;
        done_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tick && rx_act) begin          // start
                    state_d = ST_MARK;
                    cnt_d   = 1;
                end
            end
            ST_MARK: begin
                if (tick) begin
                    if (rx_act) begin
                        cnt_d = cnt_inc;
                    end else begin
                        bank_we = 1'b1;
                        idx_d   = idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin   // fill
                            state_d  = ST_DONE;
                            done_evt = 1'b1;
                        end else begin                 // mark_end
                            state_d = ST_SPACE;
                            cnt_d   = 1;
                        end
                    end
                end
            end
            ST_SPACE: begin
                if (space_over) begin                  // finish
                    bank_we  = 1'b1;
                    idx_d    = idx_q + 1'b1;
                    state_d  = ST_DONE;
                    done_evt = 1'b1;
                end else if (tick) begin
                    if (rx_act) begin
                        bank_we = 1'b1;
                        idx_d   = idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin   // fill
                            state_d  = ST_DONE;
                            done_evt = 1'b1;
                        end else begin                 // space_end
                            state_d = ST_MARK;
                            cnt_d   = 1;
                        end
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
        endcase
        if (restart) begin                             // restart
            state_d  = ST_IDLE;
            cnt_d    = '0;
            idx_d    = '0;
            bank_we  = 1'b0;
            done_evt = 1'b0;
        end
    end

endmodule

// File: rtl/ir_cap_chk.sv
module ir_cap_chk
    import ir_cap_pkg::*;
#(
    parameter int unsigned NUM_WORDS = 17,
    parameter int unsigned IDX_W     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input cap_state_e       state,
    input logic [IDX_W-1:0] idx,
    input logic             status,
    input logic             run,
    input logic             reg_wr,
    input logic [5:0]       reg_addr,
    input logic             wbit0
);

    localparam int unsigned NUM_ENTRIES = NUM_WORDS * 4;

    logic restart_wr, clr_wr;
    assign restart_wr = reg_wr && (reg_addr == A_RESTART) && wbit0;
    assign clr_wr     = reg_wr && (reg_addr == A_STATUS)  && wbit0;

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= IDX_W'(NUM_ENTRIES)); // R8

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !restart_wr) |=> (state == ST_DONE)); // R8

    AST_RESTART_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_wr |=> (state == ST_IDLE && idx == '0)); // R9

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !clr_wr) |=> status); // R10

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart_wr) |=> ($stable(state) && $stable(idx))); // R7

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && $past(state) != ST_DONE) |-> status); // R4

endmodule

bind ir_width_capture ir_cap_chk #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_q),
    .idx      (idx_q),
    .status   (status),
    .run      (run),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbit0    (reg_wdata[0])
);

// File: tb/ir_width_capture_tb.sv
module ir_width_capture_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_rx = 1'b1;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int pcyc = 1;
    bit finished = 0;
    int expv [68];

    always #5 clk = ~clk;

    ir_width_capture u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_rx     (ir_rx),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic hold(input logic lvl, input int n);
        @(negedge clk);
        ir_rx = lvl;
        repeat (n * pcyc) @(posedge clk);
    endtask

    task automatic cfg(input logic ir_en, input logic wid_en, input int d);
        wr(6'h00, (32'(d) << 8) | (32'(wid_en) << 1) | 32'(ir_en));
    endtask

    task automatic clear_exp();
        for (int e = 0; e < 68; e++) expv[e] = 0;
    endtask

    task automatic check_words(input string tag);
        logic [31:0] d, w;
        for (int i = 0; i < 17; i++) begin
            w = '0;
            for (int b = 0; b < 4; b++) w |= 32'(expv[i*4+b] & 255) << (8*b);
            rd(6'h10 + 6'(i), d);
            chk($sformatf("%s word%0d", tag, i), d, w);
        end
    endtask

    task automatic check_status(input string tag, input logic s, input logic q);
        logic [31:0] d;
        rd(6'h04, d);
        chk({tag, " status"}, d, 32'(s));
        chk({tag, " irq"}, 32'(irq), 32'(q));
    endtask

    initial begin
        #1ms;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1 reset state
        clear_exp();
        check_words("R1");
        rd(6'h00, d); chk("R1 ctrl", d, 0);
        rd(6'h01, d); chk("R1 period", d, 0);
        check_status("R1", 1'b0, 1'b0);

        // R6 period word, then R7: one enable at a time
        wr(6'h01, 32'd3); pcyc = 4;
        rd(6'h01, d); chk("R6 period readback", d, 3);
        cfg(1'b1, 1'b0, 0);
        hold(1'b0, 4); hold(1'b1, 3); hold(1'b0, 2); hold(1'b1, 5);
        check_words("R7 ir_en only");
        check_status("R7 ir_en only", 1'b0, 1'b0);
        cfg(1'b0, 1'b1, 0);
        hold(1'b0, 4); hold(1'b1, 3); hold(1'b0, 2); hold(1'b1, 5);
        check_words("R7 wid_en only");
        check_status("R7 wid_en only", 1'b0, 1'b0);

        // R2 R3 R4 R11: message with leading idle and a long mark
        cfg(1'b1, 1'b1, 0);
        hold(1'b1, 5);
        begin
            int seq [9] = '{3, 2, 300, 5, 1, 1, 7, 12, 2};
            clear_exp();
            for (int k = 0; k < 9; k++) begin
                hold((k % 2 == 0) ? 1'b0 : 1'b1, seq[k]);
                expv[k] = (seq[k] > 255) ? 255 : seq[k];
            end
            expv[9] = 255;
        end
        hold(1'b1, 260);
        repeat (4) @(posedge clk);
        check_words("R2 R3 R11 R4");
        check_status("R4 end of message", 1'b1, 1'b0);
        hold(1'b0, 3); hold(1'b1, 3);
        check_words("R4 ignored after end");

        // R10 interrupt gating and acknowledge
        wr(6'h03, 32'd1);
        check_status("R10 enabled", 1'b1, 1'b1);
        wr(6'h04, 32'd1);
        check_status("R10 acknowledged", 1'b0, 1'b0);

        // R9 restart, then R5 completion count
        wr(6'h02, 32'd1);
        clear_exp();
        check_words("R9 cleared");
        cfg(1'b1, 1'b1, 20);
        hold(1'b0, 3); hold(1'b1, 7); hold(1'b0, 4); hold(1'b1, 30);
        expv[0] = 3; expv[1] = 7; expv[2] = 4; expv[3] = 20;
        check_words("R5 completion");
        check_status("R5 completion", 1'b1, 1'b1);

        // R10 status survives restart; R9 leaves status alone
        wr(6'h02, 32'd1);
        check_status("R10 sticky over restart", 1'b1, 1'b1);
        wr(6'h04, 32'd1);

        // R8 fill all 68 entries
        cfg(1'b1, 1'b1, 0);
        clear_exp();
        hold(1'b1, 2);
        for (int e = 0; e < 68; e++) begin
            expv[e] = (e % 7) + 1;
            hold((e % 2 == 0) ? 1'b0 : 1'b1, expv[e]);
        end
        hold(1'b0, 2);
        repeat (4) @(posedge clk);
        check_status("R8 full", 1'b1, 1'b1);
        hold(1'b1, 3); hold(1'b0, 4); hold(1'b1, 260);
        check_words("R8 full and frozen");

        // R6 period sweep
        for (int pi = 0; pi < 3; pi++) begin
            int p;
            p = (pi == 0) ? 0 : ((pi == 1) ? 1 : 5);
            wr(6'h02, 32'd1);
            wr(6'h04, 32'd1);
            wr(6'h01, 32'(p)); pcyc = p + 1;
            cfg(1'b1, 1'b1, 10);
            hold(1'b0, 6); hold(1'b1, 4); hold(1'b0, 5); hold(1'b1, 15);
            rd(6'h10, d); chk($sformatf("R6 period=%0d word0", p), d, 32'h0A05_0406);
            rd(6'h11, d); chk($sformatf("R6 period=%0d word1", p), d, 0);
            check_status($sformatf("R6 period=%0d", p), 1'b1, 1'b1);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule